// File: doc/BRIEF.md
# Phase-Shifted Event PWM Generator

This block derives several pulse-width-modulated lines from one shared up-counter. A bank of compare values produces events. Event n fires in any running cycle in which the counter equals compare value n. Compare slot 0 also bounds the period: the counter returns to zero on the clock after it equals that value.

Each output line has its own set mask and clear mask, with one bit per event. The line rises on a set event and falls on a clear event. Because the rising and falling edges come from separate compare slots, two lines can share a period yet keep any phase relation to each other. When a set event and a clear event reach the same line in the same cycle, a two-bit policy field for that line decides the result.

Compare values are written into shadow copies. The active copies take the shadow values only at the period boundary, or at any time while the block is halted. A running waveform therefore never sees a period or duty value that is only partly updated. A halt input freezes the counter and suppresses all events.

Top module: `pwm_phase_gen`

## Requirements
- R1: After a synchronous reset, `count_o` is 0, every `pwm_o` bit is 0 and all compare values (shadow and active) are 0. While `halt_i` is low, `count_o` rises by one per clock.
- R2: When `halt_i` is low and `count_o` equals active compare slot 0, `count_o` is 0 on the next clock, so the period is slot 0 plus one cycles.
- R3: While `halt_i` is high, `count_o` and `pwm_o` keep their values and no event fires.
- R4: Event n fires in a running cycle when `count_o` equals active compare slot n. If event n is in bit `k*N_EV+n` of `set_mask_i` and no clear event reaches output k, then `pwm_o[k]` is 1 on the next clock.
- R5: If event n is in bit `k*N_EV+n` of `clr_mask_i` and no set event reaches output k, then `pwm_o[k]` is 0 on the next clock. With no event for output k, the output holds its value.
- R6: When set and clear events reach output k in the same cycle, `conflict_i[2k+1:2k]` decides the next value: 0 holds it, 1 sets it, 2 clears it and 3 inverts it.
- R7: A write (`mwr_en_i`, `mwr_idx_i`, `mwr_data_i`) updates only the shadow value of that slot. The active value takes the shadow value on the clock that ends a period, or on any clock while halted. A write during a running period does not change the current period.
- R8: With period 8 (slot 0 = 7), slots 1/2 at 0 and 4 give output 0 a duty of 50%. Slots 3/4 at 2 and 6 give output 1 a duty of 50%, and its rising edge comes 2 cycles (90 degrees) after that of output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_i | input | 1 | Freezes the counter and suppresses events while high |
| mwr_en_i | input | 1 | Compare shadow write strobe |
| mwr_idx_i | input | IDX_W | Compare slot selected for the write |
| mwr_data_i | input | CNT_W | Value written to the shadow slot |
| set_mask_i | input | N_OUT*N_EV | Set event masks, bit k*N_EV+n |
| clr_mask_i | input | N_OUT*N_EV | Clear event masks, bit k*N_EV+n |
| conflict_i | input | 2*N_OUT | Per-output policy when set and clear coincide |
| pwm_o | output | N_OUT | PWM lines |
| count_o | output | CNT_W | Shared counter value |

## Verification
An event is found by comparing the counter in a given cycle. Its effect on `count_o` and on `pwm_o` is visible exactly one clock later, because both are single registers. A shadow write reaches the active bank one clock after it is made, but only at a clock that ends a period or at a clock while halted. Events from the new value therefore start one cycle after that load.

The bench applies inputs on the falling edge and steps its own model on the rising edge. It then compares both outputs on the following falling edge, so each result is checked in the first cycle it is due. The directed checks of duty, phase, halt and shadow timing also sample only on falling edges.

// File: rtl/pwm_phase_pkg.sv
// Shared definitions for the phase-shifted PWM generator.
package pwm_phase_pkg;
    // Policy applied when set and clear events coincide on one output.
    typedef enum logic [1:0] {
        CF_HOLD   = 2'd0,
        CF_SET    = 2'd1,
        CF_CLEAR  = 2'd2,
        CF_TOGGLE = 2'd3
    } conflict_e;
endpackage

// File: rtl/pwm_match_bank.sv
// Compare bank: shadow and active values per slot, and event detection.
// Assumes the counter value comes from pwm_counter in the same cycle.
// The active slots reload from the shadows at the period end (event 0) or while halted.
module pwm_match_bank #(
    parameter int CNT_W = 32,
    parameter int N_EV  = 5,
    localparam int IDX_W = (N_EV > 1) ? $clog2(N_EV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [N_EV-1:0]  ev_o
);
    logic [N_EV-1:0][CNT_W-1:0] shadow_q;
    logic [N_EV-1:0][CNT_W-1:0] active_q;
    logic                       reload;

    assign reload = halt_i || ev_o[0];

    // Compare every active slot against the counter while running.
    always_comb begin
        for (int n = 0; n < N_EV; n++) begin
            ev_o[n] = !halt_i && (cnt_i == active_q[n]);
        end
    end

    generate
        for (genvar g = 0; g < N_EV; g++) begin : g_slot
            // Capture software writes into the shadow copy of slot g.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shadow_q[g] <= '0;
                end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                    shadow_q[g] <= wr_data_i;
                end
            end

            // Move the shadow into the active slot at a safe point only.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    active_q[g] <= '0;
                end else if (reload) begin
                    active_q[g] <= shadow_q[g];
                end
            end
        end
    endgenerate

    // R7
    active_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && !ev_o[0]) |=> $stable(active_q));

    // R3
    halt_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |-> (ev_o == '0));
endmodule

// File: rtl/pwm_counter.sv
// Shared period counter. It counts up while running, returns to zero after the
// cycle flagged by wrap_i and holds while halted.
module pwm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic             wrap_i,
    output logic [CNT_W-1:0] cnt_o
);
    // Advance, wrap or hold the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (!halt_i) begin
            cnt_o <= wrap_i ? '0 : cnt_o + 1'b1;
        end
    end

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && !wrap_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R2
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && wrap_i) |=> (cnt_o == '0));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> $stable(cnt_o));
endmodule

// File: rtl/pwm_out_cell.sv
// One PWM output. It reduces the event vector through its set and clear masks
// and applies the conflict policy when both hit. Events come in already gated by halt.
module pwm_out_cell
    import pwm_phase_pkg::*;
#(
    parameter int N_EV = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EV-1:0] ev_i,
    input  logic [N_EV-1:0] set_mask_i,
    input  logic [N_EV-1:0] clr_mask_i,
    input  logic [1:0]      conflict_i,
    output logic            pwm_o
);
    logic      hit_set;
    logic      hit_clr;
    logic      nxt;
    conflict_e mode;

    assign hit_set = |(ev_i & set_mask_i);
    assign hit_clr = |(ev_i & clr_mask_i);
    assign mode    = conflict_e'(conflict_i);

    // Choose the next output level from the events and the policy.
    always_comb begin
        nxt = pwm_o;
        if (hit_set && !hit_clr) begin
            nxt = 1'b1;
        end else if (hit_clr && !hit_set) begin
            nxt = 1'b0;
        end else if (hit_set && hit_clr) begin
            case (mode)
                CF_SET:    nxt = 1'b1;
                CF_CLEAR:  nxt = 1'b0;
                CF_TOGGLE: nxt = !pwm_o;
                default:   nxt = pwm_o;
            endcase
        end
    end

    // Register the output line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_o <= 1'b0;
        end else begin
            pwm_o <= nxt;
        end
    end

    // R4
    set_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_set && !hit_clr) |=> pwm_o);

    // R5
    clr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_clr && !hit_set) |=> !pwm_o);

    // R6
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_set && hit_clr && conflict_i == 2'd3) |=> (pwm_o != $past(pwm_o)));
endmodule

// File: rtl/pwm_phase_gen.sv
// Top of the phase-shifted PWM generator: one shared counter, a compare bank
// and N_OUT output cells driven by per-output event masks.
// Assumes the configuration inputs are synchronous to clk.
module pwm_phase_gen #(
    parameter int CNT_W = 32,
    parameter int N_EV  = 5,
    parameter int N_OUT = 3,
    localparam int IDX_W = (N_EV > 1) ? $clog2(N_EV) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  halt_i,
    input  logic                  mwr_en_i,
    input  logic [IDX_W-1:0]      mwr_idx_i,
    input  logic [CNT_W-1:0]      mwr_data_i,
    input  logic [N_OUT*N_EV-1:0] set_mask_i,
    input  logic [N_OUT*N_EV-1:0] clr_mask_i,
    input  logic [2*N_OUT-1:0]    conflict_i,
    output logic [N_OUT-1:0]      pwm_o,
    output logic [CNT_W-1:0]      count_o
);
    logic [N_EV-1:0] ev;

    pwm_match_bank #(.CNT_W(CNT_W), .N_EV(N_EV)) bank_i (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i),
        .wr_en_i(mwr_en_i), .wr_idx_i(mwr_idx_i), .wr_data_i(mwr_data_i),
        .cnt_i(count_o), .ev_o(ev)
    );

    pwm_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i),
        .wrap_i(ev[0]), .cnt_o(count_o)
    );

    generate
        for (genvar k = 0; k < N_OUT; k++) begin : g_out
            pwm_out_cell #(.N_EV(N_EV)) cell_i (
                .clk(clk), .rst_n(rst_n), .ev_i(ev),
                .set_mask_i(set_mask_i[k*N_EV +: N_EV]),
                .clr_mask_i(clr_mask_i[k*N_EV +: N_EV]),
                .conflict_i(conflict_i[2*k +: 2]),
                .pwm_o(pwm_o[k])
            );
        end
    endgenerate

    // R3
    halt_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> $stable(pwm_o));
endmodule

// File: tb/pwm_phase_gen_tb.sv
// Bench: a cycle model built from the requirements, random traffic and directed cases.
module pwm_phase_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 32;
    localparam int N_EV  = 5;
    localparam int N_OUT = 3;
    localparam int IDX_W = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  halt_i = 1'b1;
    logic                  mwr_en_i = 1'b0;
    logic [IDX_W-1:0]      mwr_idx_i = '0;
    logic [CNT_W-1:0]      mwr_data_i = '0;
    logic [N_OUT*N_EV-1:0] set_mask_i = '0;
    logic [N_OUT*N_EV-1:0] clr_mask_i = '0;
    logic [2*N_OUT-1:0]    conflict_i = '0;
    logic [N_OUT-1:0]      pwm_o;
    logic [CNT_W-1:0]      count_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [CNT_W-1:0] m_cnt;
    logic [CNT_W-1:0] m_sh  [N_EV];
    logic [CNT_W-1:0] m_act [N_EV];
    logic [N_OUT-1:0] m_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_phase_gen #(.CNT_W(CNT_W), .N_EV(N_EV), .N_OUT(N_OUT)) dut_i (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i),
        .mwr_en_i(mwr_en_i), .mwr_idx_i(mwr_idx_i), .mwr_data_i(mwr_data_i),
        .set_mask_i(set_mask_i), .clr_mask_i(clr_mask_i), .conflict_i(conflict_i),
        .pwm_o(pwm_o), .count_o(count_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Next output level for one line, written from the conflict rule.
    function automatic logic next_level(input logic cur, input logic s, input logic c, input logic [1:0] mode);
        if (s && !c) return 1'b1;
        if (c && !s) return 1'b0;
        if (!s && !c) return cur;
        case (mode)
            2'd1: return 1'b1;
            2'd2: return 1'b0;
            2'd3: return !cur;
            default: return cur;
        endcase
    endfunction

    // Advance the model by one clock, using the inputs held over that edge.
    task automatic model_step();
        logic [N_EV-1:0] ev;
        logic [N_OUT-1:0] nout;
        for (int n = 0; n < N_EV; n++) ev[n] = !halt_i && (m_cnt == m_act[n]);
        if (!rst_n) begin
            m_cnt = '0;
            m_out = '0;
            for (int n = 0; n < N_EV; n++) begin m_sh[n] = '0; m_act[n] = '0; end
            return;
        end
        for (int k = 0; k < N_OUT; k++) begin
            logic s, c;
            s = |(ev & set_mask_i[k*N_EV +: N_EV]);
            c = |(ev & clr_mask_i[k*N_EV +: N_EV]);
            nout[k] = next_level(m_out[k], s, c, conflict_i[2*k +: 2]);
        end
        if (halt_i || ev[0]) for (int n = 0; n < N_EV; n++) m_act[n] = m_sh[n];
        if (mwr_en_i && mwr_idx_i < N_EV) m_sh[mwr_idx_i] = mwr_data_i;
        if (!halt_i) m_cnt = ev[0] ? '0 : m_cnt + 1;
        m_out = nout;
    endtask

    // One clock, followed by a comparison against the model.
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(count_o == m_cnt, "R1 count vs model", count_o, m_cnt);
        chk(pwm_o == m_out, "R4 pwm vs model", pwm_o, m_out);
    endtask

    task automatic wr(input int idx, input int val);
        mwr_en_i = 1'b1; mwr_idx_i = IDX_W'(idx); mwr_data_i = CNT_W'(val);
        tick();
        mwr_en_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int hi0, hi1, rise0, rise1, maxc;
        logic [CNT_W-1:0] held;
        logic [N_OUT-1:0] heldp;
        void'($urandom(32'd4242));
        @(negedge clk);
        tick(); tick();
        // R1 reset state
        chk(count_o == 0, "R1 reset count", count_o, 0);
        chk(pwm_o == 0, "R1 reset pwm", pwm_o, 0);
        rst_n = 1'b1;
        // Directed: period 8, quadrature pair, toggling third line
        wr(0, 7); wr(1, 0); wr(2, 4); wr(3, 2); wr(4, 6);
        set_mask_i = '0; clr_mask_i = '0;
        set_mask_i[0*N_EV+1] = 1'b1; clr_mask_i[0*N_EV+2] = 1'b1;
        set_mask_i[1*N_EV+3] = 1'b1; clr_mask_i[1*N_EV+4] = 1'b1;
        set_mask_i[2*N_EV+1] = 1'b1; clr_mask_i[2*N_EV+1] = 1'b1;
        conflict_i = 6'b11_00_00;
        tick();
        halt_i = 1'b0;
        repeat (16) tick();
        hi0 = 0; hi1 = 0; rise0 = -1; rise1 = -1;
        for (int i = 0; i < 16; i++) begin
            heldp = pwm_o;
            tick();
            hi0 += pwm_o[0]; hi1 += pwm_o[1];
            if (!heldp[0] && pwm_o[0] && rise0 < 0) rise0 = i;
            if (!heldp[1] && pwm_o[1] && rise1 < 0 && rise0 >= 0) rise1 = i;
        end
        chk(hi0 == 8, "R8 duty out0", hi0, 8);
        chk(hi1 == 8, "R8 duty out1", hi1, 8);
        chk(rise1 - rise0 == 2, "R8 phase lag", rise1 - rise0, 2);
        // R6 toggle: a shared event on both masks inverts once per period
        heldp = pwm_o;
        repeat (8) tick();
        chk(pwm_o[2] != heldp[2], "R6 toggle per period", pwm_o[2], !heldp[2]);
        // R2 wrap and R7 shadow: a mid-period write of slot 0 waits for the boundary
        while (count_o != 1) tick();
        wr(0, 3);
        maxc = 0;
        repeat (6) begin tick(); if (count_o > maxc) maxc = count_o; end
        chk(maxc == 7, "R7 old period kept", maxc, 7);
        repeat (4) tick();
        maxc = 0;
        repeat (8) begin tick(); if (count_o > maxc) maxc = count_o; end
        chk(maxc == 3, "R2 new period limit", maxc, 3);
        // R3 halt freezes count and outputs
        halt_i = 1'b1;
        tick();
        held = count_o; heldp = pwm_o;
        repeat (5) tick();
        chk(count_o == held, "R3 count held", count_o, held);
        chk(pwm_o == heldp, "R3 pwm held", pwm_o, heldp);
        // R5 clear: release with the lines cleared on event 0
        clr_mask_i = '1; set_mask_i = '0;
        halt_i = 1'b0;
        repeat (5) tick();
        chk(pwm_o == 0, "R5 cleared lines", pwm_o, 0);
        // Random traffic, compared cycle by cycle against the model
        for (int i = 0; i < 6000; i++) begin
            halt_i = ($urandom_range(0, 19) == 0);
            mwr_en_i = ($urandom_range(0, 9) == 0);
            mwr_idx_i = IDX_W'($urandom_range(0, N_EV-1));
            mwr_data_i = CNT_W'($urandom_range(0, 12));
            if ($urandom_range(0, 49) == 0) begin
                set_mask_i = (N_OUT*N_EV)'($urandom);
                clr_mask_i = (N_OUT*N_EV)'($urandom);
                conflict_i = (2*N_OUT)'($urandom);
            end
            tick();
        end
        mwr_en_i = 1'b0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule